// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block sits between the device interrupt sources of a system and up to four processors. Devices raise and drop individual source lines, numbered 0 to 63, through two single-index request ports. The block holds one shared raw request vector, plus one enable mask for each CPU. A CPU's pending vector is its mask ANDed with the raw vector. Each CPU gets a level interrupt line, high while its pending vector is non-zero.

Alongside the level lines, the block emits per-CPU, per-source event pulses, so a downstream interrupt controller can track individual sources. A post pulse means a source has become deliverable to a CPU. A withdraw pulse means a source that was deliverable no longer is. Mask writes are compared bit by bit against the old state, so only sources whose delivery actually changed produce events.

Software uses a 64-bit register port. It can read the masks, the pending vectors and the raw vector. The masks are the only writable registers. The register is selected by the byte address divided by 64, and every access must be 64 bits wide.

Top module: `irq_route_hub`

## Requirements
- R1: After reset, all masks and the raw vector are zero. `cpu_irq` is low, no event bits are set, and `rsp_vld` is low.
- R2: `cpu_irq[c]` is high exactly when CPU c's pending vector (mask c AND raw) is non-zero. The pending vector reads back at register slot 4+c.
- R3: A source assert (`src_set_vld`, index n) sets raw bit n on the next clock edge. In the cycle after the request, `evt_post[c*64+n]` pulses for every CPU c whose mask had bit n set.
- R4: A source clear (`src_clr_vld`, index n) with raw bit n set clears that bit. In the cycle after the request, `evt_wdr[c*64+n]` pulses for every CPU c whose pending vector had bit n.
- R5: A source clear for an index whose raw bit is already zero is spurious. It leaves the raw vector unchanged and produces no event.
- R6: A valid write to mask slot c replaces mask c. A post pulses for each bit that changed and is pending under the new mask. A withdraw pulses for each bit that was pending before the write and is not pending after it. An unchanged bit produces no event.
- R7: When a source request and a mask write fall in the same cycle, the source update is applied first. The mask write is then compared against the updated raw vector. A source asserted while its mask bit is being removed therefore gives both a post and a withdraw pulse.
- R8: The register slot is the byte address divided by 64. Slots 0 to 3 are the masks, 4 to 7 the pending vectors and 8 the raw vector. A read returns, in the next cycle, the value held in the request cycle, with `rsp_vld` high and `rsp_err` low. A write response carries zero data.
- R9: Each of the following sets `rsp_err` in the response cycle, returns zero data and changes no state:
  - a size code other than 3 (size codes: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit);
  - an address not a multiple of 64;
  - a slot above 8;
  - a write to slots 4 to 8.
- R10: When a source assert and a source clear name the same index in one cycle, the clear is applied before the assert. If the raw bit was set, withdraw pulses follow the R4 rule and post pulses follow the R3 rule, and the bit stays set. If the raw bit was clear, the clear is spurious and only the assert takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set_vld | input | 1 | Device assert request |
| src_set_idx | input | 6 | Source index to assert |
| src_clr_vld | input | 1 | Device clear request |
| src_clr_idx | input | 6 | Source index to clear |
| req_vld | input | 1 | Register access valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address from block base |
| req_size | input | 2 | Access size code (3 = 64-bit) |
| req_wdata | input | 64 | Write data |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access error flag |
| rsp_rdata | output | 64 | Read data |
| cpu_irq | output | 4 | Level interrupt line per CPU |
| evt_post | output | 256 | Post pulses, bit c*64+n = CPU c, source n |
| evt_wdr | output | 256 | Withdraw pulses, same bit layout |

## Verification
The bench goes after the following corner cases:
- **Mask writes that change a bit whose raw request is clear.** A design that compares against the mask alone would post a spurious event here.
- **Mask rewrites that leave a pending bit unchanged.** A design that posts on every written one would emit duplicate posts.
- **Spurious clears.** A design that skips the raw-bit test would emit withdraws for sources that were never up.
- **A source assert colliding with a mask write that removes the same bit.** A design that applies the write first would miss the post, or report the source still pending.
- **Assert and clear of the same index in one cycle.** A design with the wrong order would leave the bit clear.
- **Rejected accesses.** Each bad size, bad alignment, unmapped slot and read-only write is followed by a read-back, so a rejected write that still changed a mask is caught.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   // byte address bits below the slot number
   localparam int unsigned SLOT_SHIFT = 6;

endpackage

// File: rtl/irq_raw_req.sv
module irq_raw_req #(
   parameter int unsigned NSRC  = 64,
   parameter int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_vld,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             clr_vld,
   input  logic [IDX_W-1:0] clr_idx,
   output logic [NSRC-1:0]  raw_q,
   output logic [NSRC-1:0]  raw_nxt,
   output logic [NSRC-1:0]  set_oh,
   output logic [NSRC-1:0]  clr_oh
);

   localparam logic [NSRC-1:0] ONE = NSRC'(1);

   logic set_ok, clr_ok;
   logic [NSRC-1:0] clr_sel;

   generate
      if (NSRC == (1 << IDX_W)) begin : g_exact
         assign set_ok = set_vld;
         assign clr_ok = clr_vld;
      end else begin : g_clip
         // indices past the last source are dropped
         assign set_ok = set_vld && (int'(set_idx) < NSRC);
         assign clr_ok = clr_vld && (int'(clr_idx) < NSRC);
      end
   endgenerate

   always_comb begin
      clr_sel = ONE << clr_idx;
      set_oh  = set_ok ? (ONE << set_idx) : '0;
      // a clear only counts when the raw bit is up
      clr_oh  = (clr_ok && |(clr_sel & raw_q)) ? clr_sel : '0;
      // clear before set
      raw_nxt = (raw_q & ~clr_oh) | set_oh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw_nxt;
   end

   p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_vld |=> |(raw_q & (ONE << $past(set_idx))));

   p_spurious_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld && !set_vld && !(|(clr_sel & raw_q))) |=> $stable(raw_q));

endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
   parameter int unsigned NSRC = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] raw_q,
   input  logic [NSRC-1:0] raw_nxt,
   input  logic [NSRC-1:0] set_oh,
   input  logic [NSRC-1:0] clr_oh,
   input  logic            wr_en,
   input  logic [NSRC-1:0] wr_mask,
   output logic [NSRC-1:0] mask_q,
   output logic [NSRC-1:0] pend,
   output logic [NSRC-1:0] post_q,
   output logic [NSRC-1:0] wdr_q
);

   logic [NSRC-1:0] mask_nxt, pend_mid, pend_new;
   logic [NSRC-1:0] dev_post, dev_wdr, sw_post, sw_wdr;

   always_comb begin
      pend     = mask_q & raw_q;
      dev_post = set_oh & mask_q;
      dev_wdr  = clr_oh & pend;
      mask_nxt = wr_en ? wr_mask : mask_q;
      // device update already applied, mask write judged against it
      pend_mid = mask_q & raw_nxt;
      pend_new = mask_nxt & raw_nxt;
      sw_post  = wr_en ? ((mask_q ^ wr_mask) & pend_new) : '0;
      sw_wdr   = wr_en ? (pend_mid & ~pend_new) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         post_q <= '0;
         wdr_q  <= '0;
      end else begin
         mask_q <= mask_nxt;
         post_q <= dev_post | sw_post;
         wdr_q  <= dev_wdr | sw_wdr;
      end
   end

   p_mask_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_q == $past(wr_mask)));

   p_wdr_gone_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wdr_q & ~post_q & pend) == '0);

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_route_pkg::*;
#(
   parameter int unsigned NSRC   = 64,
   parameter int unsigned NCPU   = 4,
   parameter int unsigned DW     = 64,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_vld,
   input  logic                 req_wr,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [1:0]           req_size,
   input  logic [NCPU*NSRC-1:0] mask_flat,
   input  logic [NCPU*NSRC-1:0] pend_flat,
   input  logic [NSRC-1:0]      raw_q,
   output logic [NCPU-1:0]      mask_we,
   output logic                 rsp_vld,
   output logic                 rsp_err,
   output logic [DW-1:0]        rsp_rdata
);

   localparam int unsigned SLOT_W   = ADDR_W - SLOT_SHIFT;
   localparam int unsigned PEND_LO  = NCPU;
   localparam int unsigned RAW_SLOT = 2 * NCPU;

   logic [SLOT_W-1:0] slot;
   logic              hit, err;
   logic [DW-1:0]     rd_val;

   always_comb begin
      slot   = req_addr[ADDR_W-1:SLOT_SHIFT];
      hit    = 1'b0;
      rd_val = '0;
      for (int c = 0; c < int'(NCPU); c++) begin
         if (slot == SLOT_W'(c)) begin
            hit                = 1'b1;
            rd_val[NSRC-1:0]   = mask_flat[c*NSRC +: NSRC];
         end
         if (slot == SLOT_W'(PEND_LO + c)) begin
            hit                = 1'b1;
            rd_val[NSRC-1:0]   = pend_flat[c*NSRC +: NSRC];
         end
      end
      if (slot == SLOT_W'(RAW_SLOT)) begin
         hit              = 1'b1;
         rd_val[NSRC-1:0] = raw_q;
      end
      err = (acc_size_e'(req_size) != SZ_DWORD)
         || (req_addr[SLOT_SHIFT-1:0] != '0)
         || !hit
         || (req_wr && (slot >= SLOT_W'(NCPU)));
      for (int c = 0; c < int'(NCPU); c++)
         mask_we[c] = req_vld && req_wr && !err && (slot == SLOT_W'(c));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld   <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_vld   <= req_vld;
         rsp_err   <= req_vld && err;
         rsp_rdata <= (req_vld && !req_wr && !err) ? rd_val : '0;
      end
   end

   p_bad_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_size != 2'd3) |=> (rsp_vld && rsp_err && rsp_rdata == '0));

   p_one_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_we));

endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub #(
   parameter int unsigned NSRC   = 64,
   parameter int unsigned NCPU   = 4,
   parameter int unsigned DW     = 64,
   parameter int unsigned ADDR_W = 12,
   localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 src_set_vld,
   input  logic [IDX_W-1:0]     src_set_idx,
   input  logic                 src_clr_vld,
   input  logic [IDX_W-1:0]     src_clr_idx,
   input  logic                 req_vld,
   input  logic                 req_wr,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [1:0]           req_size,
   input  logic [DW-1:0]        req_wdata,
   output logic                 rsp_vld,
   output logic                 rsp_err,
   output logic [DW-1:0]        rsp_rdata,
   output logic [NCPU-1:0]      cpu_irq,
   output logic [NCPU*NSRC-1:0] evt_post,
   output logic [NCPU*NSRC-1:0] evt_wdr
);

   generate
      if (NSRC > DW)         begin : g_chk_dw   $error("NSRC exceeds DW");            end
      if (NCPU < 1)          begin : g_chk_ncpu $error("NCPU must be at least 1");    end
      if ((2 * NCPU + 1) > (1 << (ADDR_W - 6)))
                             begin : g_chk_addr $error("ADDR_W too small for slots"); end
   endgenerate

   logic [NSRC-1:0]      raw_q, raw_nxt, set_oh, clr_oh;
   logic [NCPU*NSRC-1:0] mask_flat, pend_flat;
   logic [NCPU-1:0]      mask_we;

   irq_raw_req #(.NSRC(NSRC), .IDX_W(IDX_W)) i_raw (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vld (src_set_vld),
      .set_idx (src_set_idx),
      .clr_vld (src_clr_vld),
      .clr_idx (src_clr_idx),
      .raw_q   (raw_q),
      .raw_nxt (raw_nxt),
      .set_oh  (set_oh),
      .clr_oh  (clr_oh)
   );

   for (genvar c = 0; c < NCPU; c++) begin : g_lane
      irq_cpu_lane #(.NSRC(NSRC)) i_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_q   (raw_q),
         .raw_nxt (raw_nxt),
         .set_oh  (set_oh),
         .clr_oh  (clr_oh),
         .wr_en   (mask_we[c]),
         .wr_mask (req_wdata[NSRC-1:0]),
         .mask_q  (mask_flat[c*NSRC +: NSRC]),
         .pend    (pend_flat[c*NSRC +: NSRC]),
         .post_q  (evt_post[c*NSRC +: NSRC]),
         .wdr_q   (evt_wdr[c*NSRC +: NSRC])
      );
      assign cpu_irq[c] = |pend_flat[c*NSRC +: NSRC];
   end

   irq_reg_port #(.NSRC(NSRC), .NCPU(NCPU), .DW(DW), .ADDR_W(ADDR_W)) i_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_vld   (req_vld),
      .req_wr    (req_wr),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .mask_flat (mask_flat),
      .pend_flat (pend_flat),
      .raw_q     (raw_q),
      .mask_we   (mask_we),
      .rsp_vld   (rsp_vld),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );

   p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (cpu_irq == '0 && evt_post == '0 && evt_wdr == '0));

endmodule

// File: tb/test_irq_route_hub.sv
`timescale 1ns/1ps
module test_irq_route_hub;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_set_vld = 1'b0, src_clr_vld = 1'b0;
   logic [5:0]   src_set_idx = '0, src_clr_idx = '0;
   logic         req_vld = 1'b0, req_wr = 1'b0;
   logic [11:0]  req_addr = '0;
   logic [1:0]   req_size = '0;
   logic [63:0]  req_wdata = '0;
   logic         rsp_vld, rsp_err;
   logic [63:0]  rsp_rdata;
   logic [3:0]   cpu_irq;
   logic [255:0] evt_post, evt_wdr;

   always #2.5 clk = ~clk;

   irq_route_hub i_irq_route_hub (
      .clk, .rst_n, .src_set_vld, .src_set_idx, .src_clr_vld, .src_clr_idx,
      .req_vld, .req_wr, .req_addr, .req_size, .req_wdata,
      .rsp_vld, .rsp_err, .rsp_rdata, .cpu_irq, .evt_post, .evt_wdr
   );

   typedef struct packed {
      logic         rv;
      logic         re;
      logic [63:0]  rd;
      logic [3:0]   irq;
      logic [255:0] post;
      logic [255:0] wdr;
   } exp_t;

   exp_t  q[$];
   string tq[$];
   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;

   logic [63:0] m_mask [4];
   logic [63:0] m_raw;

   // driver: applies one cycle of stimulus and pushes the expected outcome
   task automatic drive(input bit sv, input int si, input bit cv, input int ci,
                        input bit rv, input bit rw, input int slot, input int sz,
                        input int lo, input logic [63:0] wd, input string tag);
      exp_t e;
      logic [63:0] raw1;
      bit err;
      @(negedge clk);
      src_set_vld = sv; src_set_idx = 6'(si);
      src_clr_vld = cv; src_clr_idx = 6'(ci);
      req_vld = rv; req_wr = rw; req_addr = 12'((slot << 6) + lo);
      req_size = 2'(sz); req_wdata = wd;
      e = '0;
      err = (sz != 3) || (lo != 0) || (slot > 8) || (rw && slot > 3);
      e.rv = rv;
      e.re = rv && err;
      if (rv && !rw && !err)
         e.rd = (slot < 4) ? m_mask[slot] :
                (slot < 8) ? (m_mask[slot-4] & m_raw) : m_raw;
      raw1 = m_raw;
      if (cv && m_raw[ci]) begin
         raw1[ci] = 1'b0;
         for (int c = 0; c < 4; c++)
            if (m_mask[c][ci] && m_raw[ci]) e.wdr[c*64+ci] = 1'b1;
      end
      if (sv) begin
         raw1[si] = 1'b1;
         for (int c = 0; c < 4; c++)
            if (m_mask[c][si]) e.post[c*64+si] = 1'b1;
      end
      if (rv && rw && !err) begin
         for (int x = 0; x < 64; x++) begin
            if (m_mask[slot][x] != wd[x] && wd[x] && raw1[x]) e.post[slot*64+x] = 1'b1;
            if (m_mask[slot][x] && raw1[x] && !(wd[x] && raw1[x])) e.wdr[slot*64+x] = 1'b1;
         end
         m_mask[slot] = wd;
      end
      m_raw = raw1;
      for (int c = 0; c < 4; c++) e.irq[c] = |(m_mask[c] & m_raw);
      q.push_back(e);
      tq.push_back(tag);
   endtask

   task automatic idle(input string tag);
      drive(0, 0, 0, 0, 0, 0, 0, 3, 0, '0, tag);
   endtask
   task automatic wr(input int slot, input logic [63:0] wd, input string tag);
      drive(0, 0, 0, 0, 1, 1, slot, 3, 0, wd, tag);
   endtask
   task automatic rd(input int slot, input string tag);
      drive(0, 0, 0, 0, 1, 0, slot, 3, 0, '0, tag);
   endtask

   // monitor: pops one expectation per driven cycle, just after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t  e;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            n_chk++;
            if (rsp_vld !== e.rv || (e.rv && (rsp_err !== e.re || rsp_rdata !== e.rd))
                || cpu_irq !== e.irq || evt_post !== e.post || evt_wdr !== e.wdr) begin
               n_fail++;
               $display("FAIL %s act: vld=%b err=%b rd=%h irq=%b post=%h wdr=%h exp: vld=%b err=%b rd=%h irq=%b post=%h wdr=%h",
                        t, rsp_vld, rsp_err, rsp_rdata, cpu_irq, evt_post, evt_wdr,
                        e.rv, e.re, e.rd, e.irq, e.post, e.wdr);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 4; c++) m_mask[c] = '0;
      m_raw = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state at the ports
      n_chk++;
      if (cpu_irq !== 4'b0 || evt_post !== '0 || evt_wdr !== '0 || rsp_vld !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset act irq=%b vld=%b exp irq=0 vld=0", cpu_irq, rsp_vld);
      end
      rd(0, "R1 mask0 reset");
      rd(6, "R1 pend2 reset");
      rd(8, "R1 raw reset");
      // R6 mask writes with no raw requests: no events
      wr(0, 64'h0000_0000_0000_00F0, "R6 mask0 write");
      wr(1, (64'd1 << 5) | (64'd1 << 40), "R6 mask1 write");
      wr(2, '1, "R6 mask2 write");
      rd(1, "R8 mask1 readback");
      // R3 assert sources
      drive(1, 5, 0, 0, 0, 0, 0, 3, 0, '0, "R3 set src5");
      drive(1, 4, 0, 0, 0, 0, 0, 3, 0, '0, "R3 set src4");
      rd(4, "R2 pend0 read");
      rd(8, "R8 raw read");
      // R5 spurious clear
      drive(0, 0, 1, 9, 0, 0, 0, 3, 0, '0, "R5 spurious clr9");
      rd(8, "R5 raw unchanged");
      // R4 real clear
      drive(0, 0, 1, 5, 0, 0, 0, 3, 0, '0, "R4 clr src5");
      // R6 bit-level comparisons
      wr(0, 64'h0, "R6 mask0 drop pending bit4");
      wr(0, 64'h10, "R6 mask0 restore bit4");
      wr(0, 64'h30, "R6 mask0 add bit5 not raised");
      wr(0, 64'h30, "R6 mask0 rewrite same value");
      // R7 collisions
      drive(1, 63, 0, 0, 1, 1, 3, 3, 0, 64'd1 << 63, "R7 set63 with mask3 enable");
      drive(1, 40, 0, 0, 1, 1, 1, 3, 0, 64'h0, "R7 set40 with mask1 removal");
      rd(5, "R2 pend1 read");
      // R9 rejected accesses, each followed by read-back
      wr(5, '1, "R9 write pend slot");
      wr(8, '1, "R9 write raw slot");
      rd(8, "R9 raw after rejected write");
      rd(12, "R9 unmapped slot");
      drive(0, 0, 0, 0, 1, 0, 0, 2, 0, '0, "R9 32-bit read");
      drive(0, 0, 0, 0, 1, 1, 0, 0, 0, 64'hFFFF, "R9 8-bit write mask0");
      drive(0, 0, 0, 0, 1, 1, 0, 3, 8, 64'hFFFF, "R9 misaligned write mask0");
      rd(0, "R9 mask0 unchanged");
      // R10 same-index assert and clear
      drive(1, 4, 1, 4, 0, 0, 0, 3, 0, '0, "R10 set+clr raised src4");
      drive(1, 7, 1, 7, 0, 0, 0, 3, 0, '0, "R10 set+clr idle src7");
      rd(8, "R10 raw final");
      rd(6, "R2 pend2 final");
      idle("R1 idle quiet");
      idle("R1 idle quiet");
      @(posedge clk);
      #2;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule